// File: doc/BRIEF.md
# Regulator Power-Good Flag Controller

This block decides the state of a regulator's power-good indication. It waits for the start-up sequencer to report that soft-start has finished. It then raises the flag and keeps watching two early-warning sources. The first is a current limit that stays engaged for a sustained window measured in microsecond ticks. The second is a die-temperature code that crosses an upper threshold. Once the flag has dropped for a thermal reason, it comes back only after the die cools below a lower threshold.

A sequencer fault or shutdown drops the flag at once. The flag then stays down until a new soft-start completion arrives. The block drives two outputs. One is an enable for the pad transistor that pulls the open-drain pin low. The other is the same decision as a registered status bit for on-chip use.

Top module: `pgood_ctrl`

## Requirements
- R1: While reset is applied and right after it, `pg_status` is 0 and `pg_pull_low` is 1.
- R2: A one-cycle `ss_done` pulse, sampled with `fault_state` low, sets `pg_status` to 1 on the second rising edge after the pulse is sampled. Before any such pulse, `pg_status` stays 0.
- R3: With the flag up, `ilim_active` held high across 64 consecutive `us_tick` pulses drops `pg_status` on the edge after the 64th tick is sampled. After 63 such ticks, the flag is still up.
- R4: Any cycle with `ilim_active` low clears the overload count. Two runs of 40 ticks split by a dropout never drop the flag.
- R5: An overload warning stays in force while `ilim_active` is low and no tick has arrived. It clears on the first `us_tick` sampled with `ilim_active` low. The flag then returns without a new `ss_done`.
- R6: `die_temp` is an unsigned 8-bit code in °C. A value above 120 drops the flag two edges later. A value of exactly 120 does not drop it.
- R7: After a thermal drop, the flag stays down for any code from 100 to 120 inclusive. It returns two edges after a code below 100 is sampled.
- R8: `fault_state` high drops `pg_status` on the next edge. After `fault_state` returns low, the flag stays down until a fresh `ss_done`.
- R9: An `ss_done` pulse sampled while `fault_state` is high has no effect.
- R10: `pg_pull_low` is always the inverse of `pg_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_done | input | 1 | One-cycle pulse: soft-start finished successfully |
| fault_state | input | 1 | Sequencer is in fault or shutdown |
| ilim_active | input | 1 | Switch current limit currently engaged |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| die_temp | input | 8 | Die temperature, unsigned °C |
| pg_pull_low | output | 1 | Enable for the open-drain pull-down |
| pg_status | output | 1 | Registered power-good status |

## Verification
On every cycle, the assertions check the following. A fault forces the flag low on the next edge. A hot latch forces it low on the edge after that. The flag rises only after a start has been recorded. The overload warning rises only on a tick taken with the current limit engaged. The hot latch is set above the upper threshold and holds inside the hysteresis band. The bench scenarios are needed for the exact tick counts at which an overload does and does not trip. They are also needed for the dropout that resets the count, and for exact threshold values such as 120 and 99. Only the scenarios can show that a pulse during a fault is ignored and that recovery waits for a fresh start.

// File: rtl/pgood_pkg.sv
package pgood_pkg;
   localparam int DEF_TEMP_W  = 8;
   localparam int DEF_HOT_C   = 120;
   localparam int DEF_COOL_C  = 100;
   localparam int DEF_OVLD_US = 64;

   typedef enum logic [1:0] {
      WARN_NONE  = 2'b00,
      WARN_OVLD  = 2'b01,
      WARN_HOT   = 2'b10,
      WARN_BOTH  = 2'b11
   } warn_e;

   function automatic logic pg_allow(input logic started, input warn_e w, input logic flt);
      return started && (w == WARN_NONE) && !flt;
   endfunction
endpackage

// File: rtl/pgood_start_trk.sv
module pgood_start_trk (
   input  logic clk,
   input  logic rst_n,
   input  logic ss_done,
   input  logic fault_state,
   output logic started
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           started <= 1'b0;
      else if (fault_state) started <= 1'b0;
      else if (ss_done)     started <= 1'b1;
   end

   // R9: a pulse seen during a fault never records a start
   assert_no_start_in_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_state && !started) |=> !started);
endmodule

// File: rtl/pgood_ovld_mon.sv
module pgood_ovld_mon #(
   parameter int OVLD_US = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic tick,
   input  logic ilim,
   output logic warn
);
   localparam int CW = $clog2(OVLD_US + 1);
   localparam logic [CW-1:0] LAST = CW'(OVLD_US - 1);
   localparam logic [CW-1:0] FULL = CW'(OVLD_US);

   initial begin
      assert (OVLD_US >= 1) else $error("OVLD_US must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         warn <= 1'b0;
      end else if (!en) begin
         cnt  <= '0;
         warn <= 1'b0;
      end else begin
         if (!ilim)                    cnt <= '0;
         else if (tick && cnt != FULL) cnt <= cnt + 1'b1;
         if (ilim && tick && cnt == LAST) warn <= 1'b1;
         else if (!ilim && tick)          warn <= 1'b0;
      end
   end

   // R3: a warning only appears on a tick taken with the limit engaged
   assert_ovld_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(warn) |-> ($past(ilim) && $past(tick)));
   // R4: a dropout leaves the count empty
   assert_cnt_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ilim |=> (cnt == '0));
   // R5: without a tick the warning cannot clear
   assert_warn_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (warn && en && !tick) |=> warn);
endmodule

// File: rtl/pgood_therm.sv
module pgood_therm #(
   parameter int TEMP_W  = 8,
   parameter int HOT_C   = 120,
   parameter int COOL_C  = 100,
   parameter bit HYST_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TEMP_W-1:0] temp,
   output logic              hot
);
   localparam logic [TEMP_W-1:0] HOT_T  = TEMP_W'(HOT_C);
   localparam logic [TEMP_W-1:0] COOL_T = TEMP_W'(COOL_C);

   initial begin
      assert (TEMP_W >= 2 && TEMP_W <= 16) else $error("TEMP_W out of range");
      assert (HOT_C < (1 << TEMP_W)) else $error("HOT_C exceeds code range");
      assert (COOL_C <= HOT_C) else $error("COOL_C must not exceed HOT_C");
   end

   generate
      if (HYST_EN) begin : g_hyst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              hot <= 1'b0;
            else if (temp > HOT_T)   hot <= 1'b1;
            else if (temp < COOL_T)  hot <= 1'b0;
         end
         // R7: inside the band the latch keeps its state
         assert_hot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (hot && temp >= COOL_T) |=> hot);
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hot <= 1'b0;
            else        hot <= (temp > HOT_T);
         end
      end
   endgenerate

   // R6: above the upper threshold the latch is set
   assert_hot_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (temp > HOT_T) |=> hot);
endmodule

// File: rtl/pgood_ctrl.sv
module pgood_ctrl #(
   parameter int TEMP_W  = pgood_pkg::DEF_TEMP_W,
   parameter int HOT_C   = pgood_pkg::DEF_HOT_C,
   parameter int COOL_C  = pgood_pkg::DEF_COOL_C,
   parameter int OVLD_US = pgood_pkg::DEF_OVLD_US,
   parameter bit HYST_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ss_done,
   input  logic              fault_state,
   input  logic              ilim_active,
   input  logic              us_tick,
   input  logic [TEMP_W-1:0] die_temp,
   output logic              pg_pull_low,
   output logic              pg_status
);
   import pgood_pkg::*;

   logic  started_q;
   logic  ovld_q;
   logic  hot_q;
   warn_e warn_w;
   logic  pg_q;

   pgood_start_trk u_start (
      .clk         (clk),
      .rst_n       (rst_n),
      .ss_done     (ss_done),
      .fault_state (fault_state),
      .started     (started_q)
   );

   pgood_ovld_mon #(.OVLD_US(OVLD_US)) u_ovld (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (started_q),
      .tick  (us_tick),
      .ilim  (ilim_active),
      .warn  (ovld_q)
   );

   pgood_therm #(
      .TEMP_W  (TEMP_W),
      .HOT_C   (HOT_C),
      .COOL_C  (COOL_C),
      .HYST_EN (HYST_EN)
   ) u_therm (
      .clk   (clk),
      .rst_n (rst_n),
      .temp  (die_temp),
      .hot   (hot_q)
   );

   assign warn_w = warn_e'({hot_q, ovld_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pg_q <= 1'b0;
      else        pg_q <= pg_allow(started_q, warn_w, fault_state);
   end

   assign pg_status   = pg_q;
   assign pg_pull_low = ~pg_q;

   // R8: a fault drops the flag on the next edge
   assert_fault_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_state |=> !pg_status);
   // R6: the hot latch holds the flag down
   assert_hot_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hot_q |=> !pg_status);
   // R2: the flag only rises once a start is on record
   assert_rise_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pg_status) |-> $past(started_q));
   // R3: a standing overload warning holds the flag down
   assert_ovld_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ovld_q |=> !pg_status);
endmodule

// File: tb/pgood_ctrl_test.sv
module pgood_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ss_done = 1'b0;
   logic       fault_state = 1'b0;
   logic       ilim_active = 1'b0;
   logic       us_tick = 1'b0;
   logic [7:0] die_temp = 8'd25;
   logic       pg_pull_low;
   logic       pg_status;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   pgood_ctrl uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .ss_done     (ss_done),
      .fault_state (fault_state),
      .ilim_active (ilim_active),
      .us_tick     (us_tick),
      .die_temp    (die_temp),
      .pg_pull_low (pg_pull_low),
      .pg_status   (pg_status)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         us_tick = 1'b1;
         step(1);
         us_tick = 1'b0;
         step(3);
      end
   endtask

   task automatic chk(input string req, input logic exp_pg);
      n_chk++;
      if (pg_status !== exp_pg || pg_pull_low !== ~exp_pg) begin
         n_bad++;
         $display("FAIL %s: pg_status=%b pg_pull_low=%b expected pg_status=%b pg_pull_low=%b",
                  req, pg_status, pg_pull_low, exp_pg, ~exp_pg);
      end
   endtask

   task automatic start_pulse();
      ss_done = 1'b1;
      step(1);
      ss_done = 1'b0;
      step(1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 during reset", 1'b0);
      rst_n = 1'b1;
      step(3);
      chk("R1 after reset, no start", 1'b0);
   endtask

   task automatic t_start();
      ss_done = 1'b1;
      step(1);
      ss_done = 1'b0;
      chk("R2 one edge after pulse", 1'b0);
      step(1);
      chk("R2 two edges after pulse", 1'b1);
      chk("R10 pin follows status", 1'b1);
   endtask

   task automatic t_overload();
      ilim_active = 1'b1;
      ticks(63);
      chk("R3 63 ticks keeps flag", 1'b1);
      ticks(1);
      chk("R3 64 ticks drops flag", 1'b0);
      ilim_active = 1'b0;
      step(3);
      chk("R5 warning held until tick", 1'b0);
      ticks(1);
      chk("R5 warning cleared by idle tick", 1'b1);
   endtask

   task automatic t_dropout();
      ilim_active = 1'b1;
      ticks(40);
      ilim_active = 1'b0;
      step(2);
      ilim_active = 1'b1;
      ticks(40);
      chk("R4 dropout resets count", 1'b1);
      ilim_active = 1'b0;
      ticks(1);
   endtask

   task automatic t_thermal();
      die_temp = 8'd120;
      step(3);
      chk("R6 code 120 keeps flag", 1'b1);
      die_temp = 8'd121;
      step(2);
      chk("R6 code 121 drops flag", 1'b0);
      die_temp = 8'd110;
      step(3);
      chk("R7 code 110 stays down", 1'b0);
      die_temp = 8'd100;
      step(3);
      chk("R7 code 100 stays down", 1'b0);
      die_temp = 8'd99;
      step(2);
      chk("R7 code 99 restores flag", 1'b1);
      die_temp = 8'd25;
      step(1);
   endtask

   task automatic t_fault();
      fault_state = 1'b1;
      step(1);
      chk("R8 fault drops flag next edge", 1'b0);
      fault_state = 1'b0;
      step(5);
      chk("R8 no recovery without new start", 1'b0);
      fault_state = 1'b1;
      ss_done = 1'b1;
      step(1);
      ss_done = 1'b0;
      fault_state = 1'b0;
      step(3);
      chk("R9 pulse during fault ignored", 1'b0);
      start_pulse();
      chk("R8 fresh start restores flag", 1'b1);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_start();
            t_overload();
            t_dropout();
            t_thermal();
            t_fault();
         end
         begin
            #2000000;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule